// File: doc/BRIEF.md
# Three-Wire Serial Command/Status Shifter

This block is a bus master that runs one full-duplex word exchange with an external controller over three wires: a serial clock it drives, a serial data line it drives, and a serial data line it reads. A host presents a command word and pulses a start request. The block then does four things in order. It frames the exchange with an opening condition. It sends the command most significant bit first. It collects one response bit per clock pulse. It closes the exchange with a stop condition. After that it presents a status word together with a one-cycle completion pulse.

Framing is done by data-line transitions while the clock is held high. The data line falls to open the exchange and rises to close it. Every pin change is followed by one step of settle time. The length of a step comes from a host-supplied divider value, which is captured when the request is accepted. In the returned status word, the uppermost bits are taken from the command, not from the wire.

Top module: `cst_master`

## Requirements
- R1: After a synchronous active-low reset, both output lines are high, both output enables are low, and busy, done and the status word are all zero.
- R2: An accepted start request raises busy on the next clock edge and sets both output enables, which then stay high until the next reset. Both lines are high during the first step.
- R3: One step after acceptance, the data line falls while the clock stays high. One step after that, the clock falls.
- R4: Exactly 32 command bits are sent, most significant first. Each bit is placed one step before its clock rise, the clock stays high for one step, and the bit is held for one step after the fall. The first rise comes four steps after acceptance, and rises follow each other every three steps.
- R5: The input line is sampled one step after each clock fall. Each sample enters the response register at bit 0, so the first sample ends up in bit 31.
- R6: Stop: the clock rises with the data line low. One step later the data line rises, and both lines stay high after that.
- R7: Status bits 31:30 equal command bits 31:30. Status bits 29:0 hold the last 30 samples. The status word holds its value until the next completion or reset.
- R8: Done is high for exactly one cycle. That cycle is the one in which the data line rises for the stop and busy falls, and it comes 100 steps after acceptance.
- R9: One step lasts step_len_i + 1 clock cycles. The value is captured when the request is accepted, and later changes have no effect on the exchange in progress.
- R10: A start request made while busy is ignored. The exchange in progress keeps its command, its timing and its result.
- R11: A reset during an exchange ends it. On the next clock edge the block is in the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| cmd_i | input | 32 | Command word, captured with the start request |
| step_len_i | input | 8 | Step length minus one, in clock cycles |
| sdi_i | input | 1 | Serial response from the controller |
| sck_o | output | 1 | Serial clock value |
| sdo_o | output | 1 | Serial command data value |
| sck_oe_o | output | 1 | Output enable for the serial clock pin |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Assembled status word |

## Verification
Two situations are hard to reach from the ports, and both land inside the timed frame. The first is a start request that arrives while an exchange is running. The second is a reset that cuts an exchange off part-way. The stimulus counts negative clock edges from the accepted request. It issues a second request, with a different command and a different step length, at a fixed point within the bit phase. In a separate run it drops reset at a fixed point within the bit phase. A bench-side controller model decodes the opening, bit and stop events off the clock edge, so the cycle in which the clock rises and the data line falls together at the stop is never mistaken for an opening condition.

// File: rtl/cst_pkg.sv
// Package: shared types for the three-wire command/status shifter.
// Assumes: nothing; contains type definitions only.
package cst_pkg;

    // Sequencer phases; each non-idle phase lasts exactly one step.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_SFALL = 3'd2,
        PH_SCLK  = 3'd3,
        PH_BDATA = 3'd4,
        PH_BHIGH = 3'd5,
        PH_BLOW  = 3'd6,
        PH_STOP  = 3'd7
    } cst_phase_e;

endpackage

// File: rtl/cst_step_timer.sv
// Module: step timer. It counts down one step per phase and flags the last
// cycle of each step.
// Assumes: capture_i and restart_i are never high together; capture_i loads
// the step length that stays in force for the whole exchange.
module cst_step_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] step_len_i,
    output logic [DIV_W-1:0] len_q_o,
    output logic             step_done_o
);

    logic [DIV_W-1:0] len_q;
    logic [DIV_W-1:0] cnt_q;

    // Hold the step length chosen when the request was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (capture_i) begin
            len_q <= step_len_i;
        end
    end

    // Count down the cycles left in the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (capture_i) begin
            cnt_q <= step_len_i;
        end else if (restart_i) begin
            cnt_q <= len_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign len_q_o     = len_q;
    assign step_done_o = (cnt_q == '0);

endmodule

// File: rtl/cst_shifter.sv
// Module: datapath. It holds the outgoing command shift register, collects
// the response samples and assembles the status word.
// Assumes: load_i comes once per exchange, before any shift or sample;
// exactly W samples arrive before finish_i.
module cst_shifter #(
    parameter int W      = 32,
    parameter int KEEP_W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] cmd_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         sdi_i,
    input  logic         finish_i,
    output logic         tx_bit_o,
    output logic         last_bit_o,
    output logic [W-1:0] status_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    logic [W-1:0]     cmd_sr;
    logic [W-1:0]     rsp_sr;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     status_q;

    // Outgoing command: load on accept, advance after each bit's data step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr <= '0;
        end else if (load_i) begin
            cmd_sr <= cmd_i;
        end else if (shift_i) begin
            cmd_sr <= {cmd_sr[W-2:0], 1'b0};
        end
    end

    // Incoming response: shift each sample in at the low end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_sr <= '0;
        end else if (load_i) begin
            rsp_sr <= '0;
        end else if (sample_i) begin
            rsp_sr <= {rsp_sr[W-2:0], sdi_i};
        end
    end

    // Count samples so the sequencer knows when the last bit is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (load_i) begin
            bit_cnt <= '0;
        end else if (sample_i) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    generate
        if (KEEP_W > 0) begin : g_keep
            logic [KEEP_W-1:0] top_q;

            // Keep the command's upper bits, which replace the sampled ones.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    top_q <= '0;
                end else if (load_i) begin
                    top_q <= cmd_i[W-1 -: KEEP_W];
                end
            end

            // Publish the status word at the end of the stop step.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status_q <= '0;
                end else if (finish_i) begin
                    status_q <= {top_q, rsp_sr[W-KEEP_W-1:0]};
                end
            end
        end else begin : g_nokeep
            // Publish the raw samples at the end of the stop step.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status_q <= '0;
                end else if (finish_i) begin
                    status_q <= rsp_sr;
                end
            end
        end
    endgenerate

    assign tx_bit_o   = cmd_sr[W-1];
    assign last_bit_o = (bit_cnt == LAST_IDX);
    assign status_o   = status_q;

endmodule

// File: rtl/cst_sequencer.sv
// Module: sequencer. It walks the opening, bit and stop phases, drives the
// pin registers and issues the datapath strobes.
// Assumes: step_done_i is high in the last cycle of each step; tx_bit_i
// already shows the next bit to send when a data step begins.
module cst_sequencer
    import cst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       step_done_i,
    input  logic       tx_bit_i,
    input  logic       last_bit_i,
    output logic       capture_o,
    output logic       restart_o,
    output logic       shift_o,
    output logic       sample_o,
    output logic       finish_o,
    output logic       sck_o,
    output logic       sdo_o,
    output logic       oe_o,
    output logic       busy_o,
    output logic       done_o,
    output cst_phase_e phase_o
);

    cst_phase_e phase, phase_n;
    logic       sck_q, sck_n;
    logic       sdo_q, sdo_n;
    logic       oe_q;
    logic       done_q;
    logic       adv;

    // Strobes: accept in idle, advance when a step runs out.
    always_comb begin
        capture_o = (phase == PH_IDLE) && start_i;
        adv       = (phase != PH_IDLE) && step_done_i;
        restart_o = adv && (phase != PH_STOP);
        shift_o   = adv && (phase == PH_BDATA);
        sample_o  = adv && (phase == PH_BLOW);
        finish_o  = adv && (phase == PH_STOP);
    end

    // Next phase and next pin levels.
    always_comb begin
        phase_n = phase;
        sck_n   = sck_q;
        sdo_n   = sdo_q;
        case (phase)
            PH_IDLE: begin
                if (start_i) begin
                    phase_n = PH_PRE;
                    sck_n   = 1'b1;
                    sdo_n   = 1'b1;
                end
            end
            default: begin
                if (step_done_i) begin
                    case (phase)
                        PH_PRE: begin
                            phase_n = PH_SFALL;
                            sdo_n   = 1'b0;
                        end
                        PH_SFALL: begin
                            phase_n = PH_SCLK;
                            sck_n   = 1'b0;
                        end
                        PH_SCLK: begin
                            phase_n = PH_BDATA;
                            sdo_n   = tx_bit_i;
                        end
                        PH_BDATA: begin
                            phase_n = PH_BHIGH;
                            sck_n   = 1'b1;
                        end
                        PH_BHIGH: begin
                            phase_n = PH_BLOW;
                            sck_n   = 1'b0;
                        end
                        PH_BLOW: begin
                            if (last_bit_i) begin
                                phase_n = PH_STOP;
                                sck_n   = 1'b1;
                                sdo_n   = 1'b0;
                            end else begin
                                phase_n = PH_BDATA;
                                sdo_n   = tx_bit_i;
                            end
                        end
                        PH_STOP: begin
                            phase_n = PH_IDLE;
                            sdo_n   = 1'b1;
                        end
                        default: begin
                            phase_n = PH_IDLE;
                        end
                    endcase
                end
            end
        endcase
    end

    // Phase and pin registers; reset parks both lines high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            sck_q <= 1'b1;
            sdo_q <= 1'b1;
        end else begin
            phase <= phase_n;
            sck_q <= sck_n;
            sdo_q <= sdo_n;
        end
    end

    // Output enables turn on at the first accepted request and stay on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (capture_o) begin
            oe_q <= 1'b1;
        end
    end

    // Completion pulse, aligned with the rising stop edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish_o;
        end
    end

    assign sck_o   = sck_q;
    assign sdo_o   = sdo_q;
    assign oe_o    = oe_q;
    assign busy_o  = (phase != PH_IDLE);
    assign done_o  = done_q;
    assign phase_o = phase;

endmodule

// File: rtl/cst_master.sv
// Module: top of the three-wire command/status shifter. It connects the
// step timer, the sequencer and the datapath.
// Assumes: synchronous active-low reset; sdi_i is stable for at least two
// steps before each sample point, as the controller changes it only after a
// clock rise.
module cst_master
    import cst_pkg::*;
#(
    parameter int W      = 32,
    parameter int KEEP_W = 2,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     cmd_i,
    input  logic [DIV_W-1:0] step_len_i,
    input  logic             sdi_i,
    output logic             sck_o,
    output logic             sdo_o,
    output logic             sck_oe_o,
    output logic             sdo_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     status_o
);

    logic             capture;
    logic             restart;
    logic             shift;
    logic             sample;
    logic             finish;
    logic             step_done;
    logic             tx_bit;
    logic             last_bit;
    logic             oe;
    logic [DIV_W-1:0] len_q;
    cst_phase_e       phase;

    cst_step_timer #(.DIV_W(DIV_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture),
        .restart_i   (restart),
        .step_len_i  (step_len_i),
        .len_q_o     (len_q),
        .step_done_o (step_done)
    );

    cst_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_done_i (step_done),
        .tx_bit_i    (tx_bit),
        .last_bit_i  (last_bit),
        .capture_o   (capture),
        .restart_o   (restart),
        .shift_o     (shift),
        .sample_o    (sample),
        .finish_o    (finish),
        .sck_o       (sck_o),
        .sdo_o       (sdo_o),
        .oe_o        (oe),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .phase_o     (phase)
    );

    cst_shifter #(.W(W), .KEEP_W(KEEP_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (capture),
        .cmd_i      (cmd_i),
        .shift_i    (shift),
        .sample_i   (sample),
        .sdi_i      (sdi_i),
        .finish_i   (finish),
        .tx_bit_o   (tx_bit),
        .last_bit_o (last_bit),
        .status_o   (status_o)
    );

    assign sck_oe_o = oe;
    assign sdo_oe_o = oe;

endmodule

// File: rtl/cst_master_chk.sv
// Module: assertion checker for cst_master, attached by bind.
// Assumes: it sees the top's ports and its captured step length.
module cst_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sck_o,
    input logic             sdo_o,
    input logic             sck_oe_o,
    input logic             sdo_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [DIV_W-1:0] len_q
);

    // R1: the lines rest high whenever no exchange is running.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sck_o && sdo_o));

    // R2: both pins are driven throughout an exchange.
    assert_oe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (sck_oe_o && sdo_oe_o));

    // R3: a data fall under a held-high clock happens only inside an exchange.
    assert_open_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sck_o && $past(sck_o) && $fell(sdo_o)) |-> busy_o);

    // R6: a data rise under a held-high clock is the stop and signals done.
    assert_stop_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sck_o && $past(sck_o) && $rose(sdo_o)) |-> done_o);

    // R8: done lasts a single cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done coincides with the return to idle.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: the captured step length does not move during an exchange.
    assert_len_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy_o && $past(busy_o)) |-> $stable(len_q));

    // R10: busy rises only in answer to a request.
    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(busy_o)) |-> $past(start_i));

endmodule

bind cst_master cst_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sck_o    (sck_o),
    .sdo_o    (sdo_o),
    .sck_oe_o (sck_oe_o),
    .sdo_oe_o (sdo_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .len_q    (len_q)
);

// File: tb/tb_cst_master.sv
`timescale 1ns/1ps
module tb_cst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cmd_i = '0;
    logic [7:0]  step_len_i = '0;
    logic        sdi_i = 1'b0;
    logic        sck_o, sdo_o, sck_oe_o, sdo_oe_o, busy_o, done_o;
    logic [31:0] status_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cst_master dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .step_len_i(step_len_i), .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o),
        .sck_oe_o(sck_oe_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o),
        .done_o(done_o), .status_o(status_o)
    );

    // Controller model: decodes events from the pins at each falling clk edge.
    int          ncnt = 0;
    logic        prev_sck = 1'b1, prev_sdo = 1'b1;
    logic [31:0] resp_q = '0;
    logic [31:0] rx = '0;
    int          nrise = 0;
    int          t_open = 0, t_sckfall = 0, t_rise0 = 0, t_stop = 0;

    always @(negedge clk) begin
        ncnt = ncnt + 1;
        if (prev_sck && sck_o && prev_sdo && !sdo_o) begin
            t_open = ncnt; t_sckfall = 0; nrise = 0; rx = '0;
        end
        if (prev_sck && !sck_o && t_sckfall == 0) t_sckfall = ncnt;
        if (!prev_sck && sck_o) begin
            if (nrise < 32) begin
                rx = {rx[30:0], sdo_o};
                if (nrise == 0) t_rise0 = ncnt;
                sdi_i = resp_q[31 - nrise];
            end
            nrise = nrise + 1;
        end
        if (prev_sck && sck_o && !prev_sdo && sdo_o) t_stop = ncnt;
        prev_sck = sck_o;
        prev_sdo = sdo_o;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One exchange; mid_req>0 issues an ignored request after that many cycles.
    task automatic run(input logic [31:0] cmd, input logic [31:0] resp,
                       input int len, input int mid_req);
        int n0, k, tstep, t_done;
        tstep = len + 1;
        resp_q = resp;
        @(negedge clk); #1;
        n0 = ncnt;
        step_len_i = 8'(len);
        cmd_i = cmd;
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk("R2", "busy after accept", {31'd0, busy_o}, 32'd1);
        chk("R2", "oe and lines in first step",
            {28'd0, sck_oe_o, sdo_oe_o, sck_o, sdo_o}, 32'hF);
        k = 0;
        t_done = 0;
        while (!done_o && k < 5000) begin
            @(negedge clk); #1;
            k++;
            if (mid_req > 0 && k == mid_req) begin
                start_i = 1'b1; cmd_i = ~cmd; step_len_i = 8'(len + 2);
            end
            if (mid_req > 0 && k == mid_req + 1) start_i = 1'b0;
        end
        t_done = ncnt;
        chk("R8", "done time", 32'(t_done), 32'(n0 + 1 + 100 * tstep));
        chk("R8", "busy low with done", {31'd0, busy_o}, 32'd0);
        chk("R3", "data fall time", 32'(t_open), 32'(n0 + 1 + tstep));
        chk("R3", "clock fall time", 32'(t_sckfall), 32'(n0 + 1 + 2 * tstep));
        chk("R4", "first rise time", 32'(t_rise0), 32'(n0 + 1 + 4 * tstep));
        chk("R4", "bits sent msb first", rx, cmd);
        chk("R4", "rise count", 32'(nrise), 32'd33);
        chk("R6", "stop rise time", 32'(t_stop), 32'(n0 + 1 + 100 * tstep));
        chk("R7", "status", status_o, {cmd[31:30], resp[29:0]});
        if (mid_req > 0) chk("R10", "status unchanged by busy request",
                             status_o, {cmd[31:30], resp[29:0]});
        @(negedge clk); #1;
        chk("R8", "done single cycle", {31'd0, done_o}, 32'd0);
        chk("R6", "lines stay high", {30'd0, sck_o, sdo_o}, 32'd3);
        chk("R2", "oe kept", {30'd0, sck_oe_o, sdo_oe_o}, 32'd3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset lines/oe/busy/done",
            {26'd0, sck_o, sdo_o, sck_oe_o, sdo_oe_o, busy_o, done_o}, 32'h30);
        chk("R1", "reset status", status_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "idle after release", {30'd0, sck_o, sdo_o}, 32'd3);

        // Walking-bit sweep at the shortest step (R4, R5, R7).
        for (int i = 0; i < 32; i++) begin
            run(32'h1 << i, ~(32'h1 << i), 0, 0);
            run(~(32'h1 << i), 32'h1 << i, 0, 0);
        end
        // Step-length sweep (R9) with mixed patterns.
        for (int l = 1; l < 4; l++) begin
            run(32'hA5C3_0F96 ^ (32'(l) << 7), 32'h5A3C_F069 + 32'(l), l, 0);
            run(32'h3FFF_FFFF, 32'hC000_0000, l, 0);
            run(32'hC000_0000, 32'h3FFF_FFFF, l, 0);
        end
        // R10: a request during the bit phase is ignored.
        run(32'h8123_4567, 32'h7654_3210, 1, 20);
        run(32'h4ABC_DEF0, 32'hFFFF_FFFF, 0, 50);

        // R11: reset in the middle of an exchange.
        resp_q = 32'h1234_5678;
        @(negedge clk); #1;
        cmd_i = 32'hDEAD_BEEF; step_len_i = 8'd1; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        repeat (60) @(negedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R11", "abort lines/oe/busy/done",
            {26'd0, sck_o, sdo_o, sck_oe_o, sdo_oe_o, busy_o, done_o}, 32'h30);
        chk("R11", "abort status cleared", status_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        run(32'h0F0F_F0F0, 32'hAAAA_5555, 2, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule